// File: doc/BRIEF.md
# RTC Oscillator-Halt and Interrupt Flag Controller

This block holds the status and control flags of a serially programmed real-time clock. It watches a halt indication from the crystal oscillator and keeps a sticky halt flag, so that software can tell whether the time data can be trusted after power-up or after a supply drop. The halt indication is only sampled while the chip-enable input is low. When the flag is set, the block clears the oscillation adjustment register and both control registers, and keeps them cleared. Clearing those registers makes both interrupt pins inactive and turns on the 32.768 kHz clock output.

The block also owns the periodic interrupt. It supports two modes. In level mode, a periodic tick raises a flag and drives the active-low interrupt A pin until software writes 0 to the flag. In pulse mode, the pin goes low for a fixed number of clock cycles on each tick, and the flag follows the pin. Software reaches every register through a plain parallel write/read port. In the full device this port sits behind the serial shifter, which is not part of this block.

Register map (2-bit address). Address 0 is the adjustment register. Address 1 is control A. Address 2 is control B. Address 3 is status: bit 0 is the halt flag and bit 1 is the interrupt flag. Control A fields: bit 0 is clock-out disable A, bit 1 selects pulse mode (1) or level mode (0), bit 2 asserts interrupt B, and bit 3 enables the periodic interrupt. Control B field: bit 0 is clock-out disable B.

Top module: `rtc_flag_ctrl`

## Requirements
- R1: After reset, the status halt bit (addr 3 bit 0) reads 1. Addresses 0 to 2 and status bit 1 read 0. int_a_n and int_b_n are 1, and clk32_out follows clk32_in.
- R2: With ce low, osc_halt passes through a two-flop synchronizer. The halt flag is 1 three clock edges after osc_halt rises and not after two edges. The flag stays 1 after osc_halt falls.
- R3: While ce is high, osc_halt never sets the halt flag.
- R4: A write to address 3 with bit 0 = 0 clears the halt flag at the next edge. A write with bit 0 = 1 leaves the flag unchanged.
- R5: While the halt flag is 1, addresses 0, 1 and 2 read 0, and writes to them are discarded.
- R6: While the halt flag is 1, int_a_n and int_b_n are 1 and clk32_out equals clk32_in.
- R7: clk32_out is held at 1 only when control A bit 0 and control B bit 0 are both 1. Otherwise it equals clk32_in.
- R8: In level mode with control A bit 3 set, a tick sets status bit 1 and drives int_a_n low. Both hold until a write to address 3 with bit 1 = 0. A write with bit 1 = 1 changes nothing.
- R9: In pulse mode with control A bit 3 set, a tick drives int_a_n low for exactly PULSE_W cycles, and status bit 1 follows the pin. Writes of 0 to status bit 1 are ignored in this mode.
- R10: When a set event and a clear-by-write hit the same flag in the same cycle, the flag ends at 1. This applies to both the halt flag and the interrupt flag.
- R11: int_b_n is the inverse of control A bit 2.
- R12: With control A bit 3 at 0, a tick leaves status bit 1 at 0 and int_a_n at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| ce | input | 1 | Chip enable; halt sensing is armed only while low |
| osc_halt | input | 1 | Asynchronous oscillator-stopped indication |
| tick | input | 1 | One-cycle periodic interrupt strobe |
| clk32_in | input | 1 | 32.768 kHz clock from the oscillator |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for addr |
| int_a_n | output | 1 | Active-low periodic interrupt pin |
| int_b_n | output | 1 | Active-low interrupt B pin |
| clk32_out | output | 1 | Gated 32.768 kHz clock output |

## Verification
The bench measures the synchronizer latency at the edge level. A design that sampled osc_halt directly would show the flag one or two edges early. The bench holds osc_halt high while ce is high. A design that ignored the arming condition would set the flag there. It also collides a tick with a clear-by-write, and a live halt with a clear-by-write: a design with the wrong priority would lose the event. It counts the low cycles of the pulse-mode interrupt while a clear is written. A counter off by one, or a mode that accepted the clear, would give the wrong width. The bench then tries to write the control registers while halted. A design that honoured those writes would re-enable interrupt B or disable the clock output during a fault.

// File: rtl/rtc_flag_pkg.sv
package rtc_flag_pkg;
   localparam int REG_AW = 2;

   typedef enum logic [REG_AW-1:0] {
      RA_ADJ  = 2'd0,
      RA_CTLA = 2'd1,
      RA_CTLB = 2'd2,
      RA_STAT = 2'd3
   } reg_addr_e;

   // control A field positions
   localparam int CA_CKDIS = 0;
   localparam int CA_PULSE = 1;
   localparam int CA_INTB  = 2;
   localparam int CA_PIE   = 3;
   // control B field positions
   localparam int CB_CKDIS = 0;
   // status field positions
   localparam int ST_HALT  = 0;
   localparam int ST_IRQ   = 1;

   localparam int MIN_DATA_W = 4;
endpackage

// File: rtl/rtc_flag_sync.sv
module rtc_flag_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rtc_flag_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[STAGES-2:0], d};
   end

   assign q = shreg[STAGES-1];
endmodule

// File: rtl/rtc_halt_flag.sv
module rtc_halt_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic halt_s,
   input  logic ce,
   input  logic clr_req,
   output logic halt_set,
   output logic halt_q
);
   // sensing is armed only while chip enable is deasserted
   assign halt_set = halt_s & ~ce;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        halt_q <= 1'b1;   // time data invalid after power-up
      else if (halt_set) halt_q <= 1'b1;   // set beats clear
      else if (clr_req)  halt_q <= 1'b0;
   end
endmodule

// File: rtl/rtc_irq_flag.sv
module rtc_irq_flag #(
   parameter int PULSE_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic pie,
   input  logic pulse_mode,
   input  logic clr_req,
   input  logic force_clr,
   output logic irq_q
);
   if (PULSE_W < 1) begin : g_bad_pulse
      $error("rtc_irq_flag: PULSE_W must be at least 1");
   end

   logic fire;
   assign fire = tick & pie;

   if (PULSE_W == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      irq_q <= 1'b0;
         else if (force_clr)              irq_q <= 1'b0;
         else if (fire)                   irq_q <= 1'b1;
         else if (pulse_mode)             irq_q <= 1'b0;
         else if (clr_req)                irq_q <= 1'b0;
      end
   end else begin : g_counted
      localparam int CW = $clog2(PULSE_W + 1);
      localparam logic [CW-1:0] LOAD = CW'(PULSE_W);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_q <= 1'b0;
            cnt_q <= '0;
         end else if (force_clr) begin
            irq_q <= 1'b0;
            cnt_q <= '0;
         end else if (fire) begin
            irq_q <= 1'b1;
            cnt_q <= pulse_mode ? LOAD : '0;
         end else if (pulse_mode) begin
            if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
               if (cnt_q == CW'(1)) irq_q <= 1'b0;
            end
         end else begin
            cnt_q <= '0;
            if (clr_req) irq_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/rtc_clkout_gate.sv
module rtc_clkout_gate #(
   parameter logic IDLE_LEVEL = 1'b1
) (
   input  logic dis_a,
   input  logic dis_b,
   input  logic clk32_in,
   output logic clk32_out
);
   // output runs unless both disable bits are set
   assign clk32_out = (dis_a & dis_b) ? IDLE_LEVEL : clk32_in;
endmodule

// File: rtl/rtc_flag_ctrl.sv
module rtc_flag_ctrl
   import rtc_flag_pkg::*;
#(
   parameter int   DATA_W      = 8,
   parameter int   SYNC_STAGES = 2,
   parameter int   PULSE_W     = 4,
   parameter logic CLKOUT_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              osc_halt,
   input  logic              tick,
   input  logic              clk32_in,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              int_a_n,
   output logic              int_b_n,
   output logic              clk32_out
);
   if (DATA_W < MIN_DATA_W) begin : g_bad_width
      $error("rtc_flag_ctrl: DATA_W too small for the field layout");
   end

   logic              halt_s;
   logic              halt_q;
   logic              halt_set;
   logic              irq_q;
   logic              hold_zero;
   logic              wr_stat;
   logic [DATA_W-1:0] adj_q;
   logic [DATA_W-1:0] ctrl1_q;
   logic [DATA_W-1:0] ctrl2_q;
   logic [DATA_W-1:0] stat_v;

   assign wr_stat   = wr_en && (reg_addr_e'(addr) == RA_STAT);
   assign hold_zero = halt_q | halt_set;

   rtc_flag_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (osc_halt),
      .q     (halt_s)
   );

   rtc_halt_flag u_halt (
      .clk      (clk),
      .rst_n    (rst_n),
      .halt_s   (halt_s),
      .ce       (ce),
      .clr_req  (wr_stat && !wdata[ST_HALT]),
      .halt_set (halt_set),
      .halt_q   (halt_q)
   );

   // adjustment and control registers, forced clear during a halt fault
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adj_q   <= '0;
         ctrl1_q <= '0;
         ctrl2_q <= '0;
      end else if (hold_zero) begin
         adj_q   <= '0;
         ctrl1_q <= '0;
         ctrl2_q <= '0;
      end else if (wr_en) begin
         case (reg_addr_e'(addr))
            RA_ADJ:  adj_q   <= wdata;
            RA_CTLA: ctrl1_q <= wdata;
            RA_CTLB: ctrl2_q <= wdata;
            default: ;
         endcase
      end
   end

   rtc_irq_flag #(.PULSE_W(PULSE_W)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .pie        (ctrl1_q[CA_PIE]),
      .pulse_mode (ctrl1_q[CA_PULSE]),
      .clr_req    (wr_stat && !wdata[ST_IRQ]),
      .force_clr  (hold_zero),
      .irq_q      (irq_q)
   );

   rtc_clkout_gate #(.IDLE_LEVEL(CLKOUT_IDLE)) u_ckgate (
      .dis_a     (ctrl1_q[CA_CKDIS]),
      .dis_b     (ctrl2_q[CB_CKDIS]),
      .clk32_in  (clk32_in),
      .clk32_out (clk32_out)
   );

   assign int_a_n = ~(irq_q & ctrl1_q[CA_PIE]);
   assign int_b_n = ~ctrl1_q[CA_INTB];

   always_comb begin
      stat_v          = '0;
      stat_v[ST_HALT] = halt_q;
      stat_v[ST_IRQ]  = irq_q;
      case (reg_addr_e'(addr))
         RA_ADJ:  rdata = adj_q;
         RA_CTLA: rdata = ctrl1_q;
         RA_CTLB: rdata = ctrl2_q;
         default: rdata = stat_v;
      endcase
   end
endmodule

// File: rtl/rtc_flag_ctrl_chk.sv
module rtc_flag_ctrl_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce,
   input logic              wr_en,
   input logic [1:0]        addr,
   input logic [DATA_W-1:0] wdata,
   input logic              halt_q,
   input logic              halt_set,
   input logic [DATA_W-1:0] adj_q,
   input logic [DATA_W-1:0] ctrl1_q,
   input logic [DATA_W-1:0] ctrl2_q,
   input logic              int_a_n,
   input logic              int_b_n,
   input logic              clk32_out
);
   assert_regs_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |-> (adj_q == '0 && ctrl1_q == '0 && ctrl2_q == '0));

   assert_halt_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !(wr_en && addr == 2'd3 && !wdata[0])) |=> halt_q);

   assert_armed_by_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt_q) |-> !$past(ce));

   assert_write_one_noop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt_q && !halt_set && wr_en && addr == 2'd3 && wdata[0]) |=> !halt_q);

   assert_pins_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |-> (int_a_n && int_b_n));

   assert_clkout_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl1_q[0] && ctrl2_q[0]) |-> clk32_out);

   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      halt_set |=> halt_q);
endmodule

bind rtc_flag_ctrl rtc_flag_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .ce        (ce),
   .wr_en     (wr_en),
   .addr      (addr),
   .wdata     (wdata),
   .halt_q    (halt_q),
   .halt_set  (halt_set),
   .adj_q     (adj_q),
   .ctrl1_q   (ctrl1_q),
   .ctrl2_q   (ctrl2_q),
   .int_a_n   (int_a_n),
   .int_b_n   (int_b_n),
   .clk32_out (clk32_out)
);

// File: tb/rtc_flag_ctrl_tb.sv
`timescale 1ns/1ps
module rtc_flag_ctrl_tb_top;
   localparam int PW = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ce = 1'b0;
   logic       osc_halt = 1'b0;
   logic       tick = 1'b0;
   logic       clk32_in = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       int_a_n, int_b_n, clk32_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   logic [7:0] mdl [3];

   always #4 clk = ~clk;

   rtc_flag_ctrl #(.DATA_W(8), .SYNC_STAGES(2), .PULSE_W(PW)) dut_i (
      .clk(clk), .rst_n(rst_n), .ce(ce), .osc_halt(osc_halt), .tick(tick),
      .clk32_in(clk32_in), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .int_a_n(int_a_n), .int_b_n(int_b_n), .clk32_out(clk32_out)
   );

   function automatic logic exp_clkout(logic da, logic db, logic ci);
      return (da & db) ? 1'b1 : ci;
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic pulse_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [7:0] v;
      int lows;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd3, v); check("R1 status", v, 8'h01);
      rd(2'd0, v); check("R1 adj", v, 8'h00);
      rd(2'd1, v); check("R1 ctla", v, 8'h00);
      rd(2'd2, v); check("R1 ctlb", v, 8'h00);
      check("R1 pins", {6'd0, int_a_n, int_b_n}, 8'h03);
      clk32_in = 1'b0; #1; check("R1 clkout", {7'd0, clk32_out}, 8'h00);

      // R4 write 1 keeps halt, write 0 clears
      wr(2'd3, 8'h03); rd(2'd3, v); check("R4 write one", v, 8'h01);
      wr(2'd3, 8'h02); rd(2'd3, v); check("R4 clear", v, 8'h00);
      wr(2'd3, 8'h03); rd(2'd3, v); check("R4 write one when clear", v, 8'h00);

      // R11 interrupt B and R7 clock gating
      wr(2'd1, 8'h04); #1; check("R11 intb low", {7'd0, int_b_n}, 8'h00);
      wr(2'd1, 8'h00); #1; check("R11 intb high", {7'd0, int_b_n}, 8'h01);
      wr(2'd1, 8'h01); wr(2'd2, 8'h01);
      clk32_in = 1'b0; #1; check("R7 held", {7'd0, clk32_out}, 8'h01);
      wr(2'd2, 8'h00);
      clk32_in = 1'b0; #1; check("R7 one disable", {7'd0, clk32_out}, 8'h00);

      // random register traffic (R5 clear path off, R7, R11)
      mdl[0] = 8'h00; mdl[1] = 8'h01; mdl[2] = 8'h00;
      for (int i = 0; i < 200; i++) begin
         logic [1:0] a;
         logic [7:0] d;
         a = 2'($urandom_range(0, 2));
         d = 8'($urandom);
         d[3] = 1'b0;              // no periodic enable here
         wr(a, d); mdl[a] = d;
         rd(a, v); check("R5 readback", v, mdl[a]);
         clk32_in = 1'($urandom); #1;
         check("R7 random", {7'd0, clk32_out},
               {7'd0, exp_clkout(mdl[1][0], mdl[2][0], clk32_in)});
         check("R11 random", {7'd0, int_b_n}, {7'd0, ~mdl[1][2]});
      end
      wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);

      // R12 tick without enable
      pulse_tick(); rd(2'd3, v); check("R12 flag", v, 8'h00);
      check("R12 pin", {7'd0, int_a_n}, 8'h01);

      // R8 level mode
      wr(2'd1, 8'h08);
      pulse_tick(); rd(2'd3, v); check("R8 set flag", v, 8'h02);
      check("R8 pin low", {7'd0, int_a_n}, 8'h00);
      wr(2'd3, 8'h03); rd(2'd3, v); check("R8 write one", v, 8'h02);
      repeat (5) @(negedge clk);
      check("R8 pin held", {7'd0, int_a_n}, 8'h00);
      wr(2'd3, 8'h01); rd(2'd3, v); check("R8 clear", v, 8'h00);
      check("R8 pin released", {7'd0, int_a_n}, 8'h01);

      // R10 tick and clear collide
      @(negedge clk);
      tick = 1'b1; wr_en = 1'b1; addr = 2'd3; wdata = 8'h01;
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0;
      rd(2'd3, v); check("R10 irq set wins", v, 8'h02);
      wr(2'd3, 8'h01);

      // R9 pulse mode
      wr(2'd1, 8'h0A);
      pulse_tick();
      lows = 0;
      for (int i = 0; i < 8; i++) begin
         #1;
         if (!int_a_n) lows++;
         if (i == 0) begin
            rd(2'd3, v); check("R9 flag follows", v, 8'h02);
         end
         if (i == 1) begin wr_en = 1'b1; addr = 2'd3; wdata = 8'h01; end
         else wr_en = 1'b0;
         @(negedge clk);
      end
      check("R9 pulse width", 8'(lows), 8'(PW));
      rd(2'd3, v); check("R9 flag after", v, 8'h00);
      wr(2'd1, 8'h00);

      // R3 ce high blocks sensing
      ce = 1'b1; osc_halt = 1'b1;
      repeat (6) @(negedge clk);
      rd(2'd3, v); check("R3 ignored", v, 8'h00);
      osc_halt = 1'b0;
      repeat (4) @(negedge clk);
      ce = 1'b0;
      repeat (2) @(negedge clk);
      rd(2'd3, v); check("R3 after", v, 8'h00);

      // R2 R5 R6 halt event with registers loaded
      wr(2'd0, 8'h5A); wr(2'd1, 8'h0D); wr(2'd2, 8'h01);
      clk32_in = 1'b0; #1; check("R7 held pre", {7'd0, clk32_out}, 8'h01);
      check("R11 pre", {7'd0, int_b_n}, 8'h00);
      @(negedge clk); osc_halt = 1'b1;
      @(negedge clk); @(negedge clk);
      rd(2'd3, v); check("R2 not yet", v, 8'h00);
      @(negedge clk);
      rd(2'd3, v); check("R2 set", v, 8'h01);
      rd(2'd0, v); check("R5 adj", v, 8'h00);
      rd(2'd1, v); check("R5 ctla", v, 8'h00);
      rd(2'd2, v); check("R5 ctlb", v, 8'h00);
      check("R6 pins", {6'd0, int_a_n, int_b_n}, 8'h03);
      clk32_in = 1'b0; #1; check("R6 clk low", {7'd0, clk32_out}, 8'h00);
      clk32_in = 1'b1; #1; check("R6 clk high", {7'd0, clk32_out}, 8'h01);
      // R10 halt set vs clear
      wr(2'd3, 8'h02); rd(2'd3, v); check("R10 halt set wins", v, 8'h01);
      wr(2'd1, 8'h04); rd(2'd1, v); check("R5 write ignored", v, 8'h00);
      check("R5 intb quiet", {7'd0, int_b_n}, 8'h01);
      osc_halt = 1'b0;
      repeat (4) @(negedge clk);
      rd(2'd3, v); check("R2 sticky", v, 8'h01);
      wr(2'd3, 8'h02); rd(2'd3, v); check("R4 rearm clear", v, 8'h00);
      wr(2'd1, 8'h04); rd(2'd1, v); check("R5 writes resume", v, 8'h04);

      finish_run();
   end
endmodule